// File: doc/BRIEF.md
# Folded Stage Engine

This block applies a chain of N transform steps to each data word while owning only one copy of the transform logic. A stage counter cycles through the values 0 to N-1. Each counter value is one logical stage. The shared transform receives both the counter value and an operand. In stage 0 the operand is the word at the head of an upstream FIFO. In every later stage the operand is the single recirculating state register.

In the last stage the transform output is pushed into a downstream FIFO rather than stored. The upstream side is seen as a not-empty flag, a head word and a dequeue strobe. The downstream side is seen as a full flag, a push strobe and the word to push.

At most one word is in flight at any time. With an upstream that never runs dry and a downstream that never fills, one word enters and one word leaves every N cycles. This is the area-for-throughput exchange that folding is meant to make.

Top module: `folded_engine`

## Requirements
- R1: While `rst_n` is low, `in_deq` and `out_enq` are low, and the stage counter is cleared to 0, so the first word after reset is taken in the first cycle in which `in_valid` is high.
- R2: `in_deq` is high only in stage 0 and only while `in_valid` is high. In that cycle the head word `in_data` is the transform operand.
- R3: The transform step is g(s,x) = rotate_left(x + KBASE + s*KSTEP, ROT), computed modulo 2^W. The word pushed for input x equals g(N-1, ... g(1, g(0,x))).
- R4: With `in_valid` held high and `out_full` held low, `in_deq` pulses exactly once every N cycles, and `out_enq` pulses exactly once every N cycles.
- R5: In stage 0 with `in_valid` low, nothing fires. `in_deq` and `out_enq` stay low and the engine stays in stage 0.
- R6: In stage N-1 with `out_full` high, `out_enq` is low, the engine does not advance, and `out_data` holds its value until `out_full` falls.
- R7: For N>1, `in_deq` and `out_enq` alternate: exactly one push follows each dequeue before the next dequeue. For N=1, dequeue and push occur in the same cycle.
- R8: After a push the counter wraps to stage 0, so a waiting input word is dequeued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream FIFO is not empty |
| in_data | input | W | Upstream FIFO head word |
| in_deq | output | 1 | Dequeue strobe to upstream FIFO |
| out_full | input | 1 | Downstream FIFO is full |
| out_data | output | W | Word to push downstream |
| out_enq | output | 1 | Push strobe to downstream FIFO |

## Verification
The bench builds two instances. The first has W=16, N=4 and ROT=3. It exercises the recirculation through the state register, the two middle stages in which neither strobe may fire, and stalls at both ends of the stage sequence. The second has N=1, where the first and last stage are the same cycle. That instance shows that a single step moves a word straight from input to output, and that a full downstream also blocks the dequeue.

// File: rtl/folded_engine.sv
module folded_engine #(
  parameter int unsigned W     = 16,
  parameter int unsigned N     = 4,
  parameter int unsigned ROT   = 3,
  parameter int unsigned KBASE = 'h1234,
  parameter int unsigned KSTEP = 'h0F0F,
  localparam int unsigned SW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_deq,
  input  logic         out_full,
  output logic [W-1:0] out_data,
  output logic         out_enq
);
  localparam logic [SW-1:0] LAST = SW'(N - 1);

  logic [SW-1:0]  stg;
  logic [W-1:0]   acc;
  logic [W-1:0]   opnd, kval, sum;
  logic [2*W-1:0] dbl;
  logic           at_first, at_last, fire;

  assign at_first = (stg == '0);
  assign at_last  = (stg == LAST);
  assign fire     = rst_n & (!at_first | in_valid) & (!at_last | !out_full);

  assign opnd = at_first ? in_data : acc;
  assign kval = W'(KBASE) + W'(KSTEP) * W'(stg);
  assign sum  = opnd + kval;
  assign dbl  = {sum, sum};

  assign out_data = dbl[2*W-1-ROT -: W];
  assign in_deq   = fire & at_first;
  assign out_enq  = fire & at_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    stg <= '0;
    else if (fire) stg <= at_last ? '0 : stg + SW'(1);

  always_ff @(posedge clk)
    if (fire && !at_last) acc <= out_data;
endmodule

// File: rtl/folded_engine_chk.sv
module folded_engine_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 16,
  parameter int unsigned SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_deq,
  input logic          out_full,
  input logic          out_enq,
  input logic [W-1:0]  out_data,
  input logic [SW-1:0] stg
);
  localparam logic [SW-1:0] LAST = SW'(N - 1);

  logic infl;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) infl <= 1'b0;
    else        infl <= (infl | in_deq) & ~out_enq;

  a_r1_stage_range: assert property (@(posedge clk) disable iff (!rst_n)
    stg <= LAST);
  a_r2_deq_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_deq |-> in_valid);
  a_r5_wait_input: assert property (@(posedge clk) disable iff (!rst_n)
    (stg == '0 && !in_valid) |=> stg == '0);
  a_r6_no_enq_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_enq |-> !out_full);
  a_r8_wrap_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    out_enq |=> stg == '0);

  if (N > 1) begin : g_multi
    a_r6_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
      (stg == LAST && out_full) |=> (stg == LAST && $stable(out_data)));
    a_r7_deq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      in_deq |-> !infl);
    a_r7_enq_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      out_enq |-> infl);
  end else begin : g_single
    a_r7_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      in_deq == out_enq);
  end
endmodule

bind folded_engine folded_engine_chk #(.N(N), .W(W), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_deq(in_deq),
  .out_full(out_full), .out_enq(out_enq), .out_data(out_data), .stg(stg)
);

// File: tb/tb_folded_engine.sv
`timescale 1ns/1ps
module tb_folded_engine;
  localparam int unsigned W = 16, N = 4, ROT = 3;
  localparam int unsigned KB = 'h1234, KS = 'h0F0F;
  localparam int NV = 8;
  // data[31:16], idle cycles before[15:8], full cycles at last stage[7:0]
  localparam logic [31:0] VEC [NV] = '{
    {16'h0000, 8'd0, 8'd0}, {16'hFFFF, 8'd0, 8'd0},
    {16'h8000, 8'd2, 8'd0}, {16'h1357, 8'd0, 8'd3},
    {16'hA5A5, 8'd1, 8'd1}, {16'h0001, 8'd0, 8'd0},
    {16'hDEAD, 8'd3, 8'd2}, {16'h7FFF, 8'd0, 8'd0}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_full = 0, in_deq, out_enq;
  logic [W-1:0] in_data = '0, out_data;
  logic v1 = 0, f1 = 0, deq1, enq1;
  logic [W-1:0] d1 = '0, o1;
  int total = 0, bad = 0;
  logic [W-1:0] held;

  always #4 clk = ~clk;

  folded_engine #(.W(W), .N(N), .ROT(ROT), .KBASE(KB), .KSTEP(KS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_deq(in_deq), .out_full(out_full), .out_data(out_data), .out_enq(out_enq));

  folded_engine #(.W(W), .N(1), .ROT(ROT), .KBASE(KB), .KSTEP(KS)) dut_n1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_data(d1),
    .in_deq(deq1), .out_full(f1), .out_data(o1), .out_enq(enq1));

  function automatic logic [W-1:0] step(int s, logic [W-1:0] x);
    logic [W-1:0] t;
    t = x + W'(KB) + W'(KS) * W'(s);
    return (t << ROT) | (t >> (W - ROT));
  endfunction

  function automatic logic [W-1:0] chain(int n, logic [W-1:0] x);
    logic [W-1:0] y = x;
    for (int s = 0; s < n; s++) y = step(s, y);
    return y;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #200000;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    in_valid = 1; in_data = 16'h4242; v1 = 1;
    #1 chk(!in_deq && !out_enq && !deq1 && !enq1, "R1 strobes low in reset",
           {in_deq, out_enq, deq1, enq1}, 0);
    tick(); tick();
    rst_n = 1;
    in_valid = 0; v1 = 0;

    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] x = VEC[i][31:16];
      for (int g = 0; g < int'(VEC[i][15:8]); g++) begin
        #1 chk(!in_deq && !out_enq, "R5 idle stage 0", {in_deq, out_enq}, 0);
        tick();
      end
      in_valid = 1; in_data = x;
      #1 chk(in_deq == 1, "R2/R8 dequeue at stage 0", in_deq, 1);
      tick();
      in_valid = 1; in_data = ~x;
      for (int s = 1; s < N - 1; s++) begin
        #1 chk(!in_deq && !out_enq, "R4/R7 middle stage quiet", {in_deq, out_enq}, 0);
        tick();
      end
      in_valid = 0;
      if (VEC[i][7:0] != 0) begin
        out_full = 1;
        #1 held = out_data;
        for (int f = 0; f < int'(VEC[i][7:0]); f++) begin
          #1 chk(!out_enq && !in_deq && out_data == held, "R6 stall at last stage",
                 {out_enq, out_data}, {1'b0, held});
          tick();
        end
        out_full = 0;
      end
      #1 chk(out_enq && out_data == chain(N, x), "R3 pushed result",
             {out_enq, out_data}, {1'b1, chain(N, x)});
      tick();
    end

    // R4: back-to-back words, dequeue period is N cycles
    in_valid = 1; in_data = 16'h0F0F;
    for (int c = 0; c < 3 * N; c++) begin
      #1 chk(in_deq == (c % N == 0), "R4 dequeue period", in_deq, (c % N == 0));
      chk(out_enq == (c % N == N - 1), "R4 push period", out_enq, (c % N == N - 1));
      tick();
    end
    in_valid = 0;

    // N=1 instance: R7 same-cycle dequeue and push, R6 full blocks all
    v1 = 1; d1 = 16'hBEEF;
    #1 chk(deq1 && enq1 && o1 == chain(1, 16'hBEEF), "R7 single stage pass",
           {deq1, enq1, o1}, {2'b11, chain(1, 16'hBEEF)});
    f1 = 1;
    #1 chk(!deq1 && !enq1, "R6 single stage full", {deq1, enq1}, 0);
    tick();
    f1 = 0; d1 = 16'h0000;
    #1 chk(deq1 && enq1 && o1 == chain(1, 16'h0000), "R3 single stage value",
           {deq1, enq1, o1}, {2'b11, chain(1, 16'h0000)});
    v1 = 0;
    tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule